// File: doc/BRIEF.md
# I2C SCL Phase Timer

This block times the serial clock of an I2C master from a faster source clock. One packed control word sets the length of the low phase and, optionally, a separate length for the high phase. With the high-phase field left at zero both phases use the same count, which gives the even duty cycle of standard mode. With the high-phase field set to about half the low-phase count, the result is the roughly one-third high, two-thirds low waveform that fast and fast-plus rates use. Every phase lasts its programmed count plus a fixed overhead of three source cycles. For a given source clock `f_src` and target bus rate `f_bus`, software derives the counts as follows. For standard mode the low count is `(f_src / f_bus) / 2 - 3` and the high field is zero. For fast mode the low count is `((f_src / f_bus) - 6) * 2 / 3` and the high field is half of that. Bus rates of zero or above 1 MHz are not programmed.

A bit-level engine consumes the outputs. One output holds SCL driven low, one strobe marks each falling edge and another marks each rising edge. The engine feeds the sampled SCL line back in. While SCL is released but still reads low, the high-phase count stands still, so a target can stretch the clock. Lowering the run enable releases SCL at once and parks the timer.

Top module: `i2c_scl_gen`

## Requirements
- R1: After synchronous reset the SCL drive output is 0 (released), and neither edge strobe is asserted.
- R2: The low-phase count occupies control bits [7:0]. Each low phase holds the drive output at 1 for that count plus 3 cycles.
- R3: The high-phase count occupies control bits [23:16]. When it is non-zero, each high phase holds the drive output at 0 for that count plus 3 cycles, provided the sensed line stays high.
- R4: When the high-phase field is zero, the high phase lasts the low-phase count plus 3 cycles. This gives a symmetric period.
- R5: The fall strobe is high for exactly the first cycle of each low phase. The rise strobe is high for exactly the first cycle of each high phase. The two strobes are never high together.
- R6: During a high phase, every cycle in which the sensed line reads 0 adds one cycle to that phase. This also holds in the cycle the count would otherwise end.
- R7: When the run enable is 0 at a clock edge, the drive output is 0 after that edge and no strobe is produced, even if a phase was due to end in that cycle.
- R8: When the run enable goes from 0 to 1 while the timer is idle, the next cycle begins a low phase, with the drive output at 1 and the fall strobe at 1.
- R9: The control word is sampled only at the start of each phase. A change during a phase affects only the phases that start later.
- R10: Control bits [15:8], which include the high-speed divider field at [10:8], have no effect on any phase length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Run enable; 0 parks the timer with SCL released |
| ctl_word | input | 24 | Packed phase counts: low [7:0], unused [15:8], high [23:16] |
| scl_sense | input | 1 | Sampled SCL line level, already synchronized |
| scl_drive_low | output | 1 | 1 while SCL is to be held low |
| scl_fall_stb | output | 1 | One-cycle pulse on the first cycle of a low phase |
| scl_rise_stb | output | 1 | One-cycle pulse on the first cycle of a high phase |

## Verification
Two pairs of events can land in the same cycle. In the first, the run enable falls in the final cycle of a low phase, when the count has expired. The bench lowers the enable at exactly that cycle and expects the line to be released with no rise strobe, so disable takes priority over the phase change. In the second, a target holds SCL low across the cycle in which the high count would end. The bench keeps the sensed line low for longer than the whole high phase and expects the high phase to last its programmed length plus every held cycle, followed by a normal fall strobe.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;

  // fixed cycles added to every programmed phase count
  localparam int unsigned PHASE_OVERHEAD = 3;
endpackage

// File: rtl/i2c_scl_ctl_decode.sv
module i2c_scl_ctl_decode
  import i2c_scl_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic [DIV_W-1:0] low_field,
  input  logic [DIV_W-1:0] high_field,
  output logic [DIV_W:0]   low_load,
  output logic [DIV_W:0]   high_load
);
  localparam int unsigned CNT_W = DIV_W + 1;
  localparam logic [CNT_W-1:0] EXTRA = CNT_W'(PHASE_OVERHEAD - 1);

  always_comb begin
    low_load = {1'b0, low_field} + EXTRA;
    if (high_field == '0) begin
      high_load = low_load;
    end else begin
      high_load = {1'b0, high_field} + EXTRA;
    end
  end
endmodule

// File: rtl/i2c_scl_phase_cnt.sv
module i2c_scl_phase_cnt #(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (dec && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen
  import i2c_scl_pkg::*;
#(
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned HI_LSB = 16,
  localparam int unsigned CTL_W = HI_LSB + DIV_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic [CTL_W-1:0] ctl_word,
  input  logic             scl_sense,
  output logic             scl_drive_low,
  output logic             scl_fall_stb,
  output logic             scl_rise_stb
);
  localparam int unsigned CNT_W = DIV_W + 1;

  scl_phase_e       phase_q, phase_d;
  logic [CNT_W-1:0] low_load, high_load, load_val;
  logic             cnt_load, cnt_dec, pick_high, cnt_expired;
  logic             ctl_unused_bits;

  // bits between the two count fields carry nothing for timing
  assign ctl_unused_bits = ^ctl_word[HI_LSB-1:DIV_W];

  i2c_scl_ctl_decode #(.DIV_W(DIV_W)) u_decode (
    .low_field (ctl_word[DIV_W-1:0]),
    .high_field(ctl_word[HI_LSB +: DIV_W]),
    .low_load  (low_load),
    .high_load (high_load)
  );

  assign load_val = pick_high ? high_load : low_load;

  i2c_scl_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .load    (cnt_load),
    .load_val(load_val),
    .dec     (cnt_dec),
    .expired (cnt_expired)
  );

  always_comb begin
    phase_d   = phase_q;
    cnt_load  = 1'b0;
    cnt_dec   = 1'b0;
    pick_high = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (run_en) begin
          phase_d  = PH_LOW;
          cnt_load = 1'b1;
        end
      end
      PH_LOW: begin
        if (!run_en) begin
          phase_d = PH_IDLE;
        end else if (cnt_expired) begin
          phase_d   = PH_HIGH;
          cnt_load  = 1'b1;
          pick_high = 1'b1;
        end else begin
          cnt_dec = 1'b1;
        end
      end
      PH_HIGH: begin
        if (!run_en) begin
          phase_d = PH_IDLE;
        end else if (scl_sense) begin
          if (cnt_expired) begin
            phase_d  = PH_LOW;
            cnt_load = 1'b1;
          end else begin
            cnt_dec = 1'b1;
          end
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q       <= PH_IDLE;
      scl_drive_low <= 1'b0;
      scl_fall_stb  <= 1'b0;
      scl_rise_stb  <= 1'b0;
    end else begin
      phase_q       <= phase_d;
      scl_drive_low <= (phase_d == PH_LOW);
      scl_fall_stb  <= (phase_d == PH_LOW) && (phase_q != PH_LOW);
      scl_rise_stb  <= (phase_d == PH_HIGH) && (phase_q == PH_LOW);
    end
  end
endmodule

module i2c_scl_gen_chk (
  input logic clk,
  input logic rst,
  input logic run_en,
  input logic scl_sense,
  input logic scl_drive_low,
  input logic scl_fall_stb,
  input logic scl_rise_stb
);
  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({scl_fall_stb, scl_rise_stb}));

  assert_fall_drives_R5: assert property (@(posedge clk) disable iff (rst)
    scl_fall_stb |-> scl_drive_low);

  assert_rise_release_R5: assert property (@(posedge clk) disable iff (rst)
    scl_rise_stb |-> (!scl_drive_low && $past(scl_drive_low)));

  assert_disable_release_R7: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> (!scl_drive_low && !scl_fall_stb && !scl_rise_stb));

  assert_stretch_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (run_en && $past(run_en) && !scl_drive_low && !scl_sense) |=> !scl_drive_low);
endmodule

bind i2c_scl_gen i2c_scl_gen_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .run_en       (run_en),
  .scl_sense    (scl_sense),
  .scl_drive_low(scl_drive_low),
  .scl_fall_stb (scl_fall_stb),
  .scl_rise_stb (scl_rise_stb)
);

// File: tb/i2c_scl_gen_tb_top.sv
module i2c_scl_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run_en = 1'b0;
  logic [23:0] ctl_word = '0;
  logic        hold_low = 1'b0;
  logic        scl_sense;
  logic        scl_drive_low, scl_fall_stb, scl_rise_stb;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  assign scl_sense = ~scl_drive_low & ~hold_low;

  i2c_scl_gen dut_i (
    .clk          (clk),
    .rst          (rst),
    .run_en       (run_en),
    .ctl_word     (ctl_word),
    .scl_sense    (scl_sense),
    .scl_drive_low(scl_drive_low),
    .scl_fall_stb (scl_fall_stb),
    .scl_rise_stb (scl_rise_stb)
  );

  function automatic logic [23:0] mk(input int lo, input int hi, input int mid);
    return {hi[7:0], mid[7:0], lo[7:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic stop_run();
    @(negedge clk);
    run_en = 1'b0;
    hold_low = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic start_run(input logic [23:0] w);
    @(negedge clk);
    ctl_word = w;
    run_en = 1'b1;
  endtask

  // measure one full period starting at a fall strobe
  task automatic measure(input string req, input int exp_lo, input int exp_hi);
    int nlo, nhi, g;
    bit ok;
    ok = 1'b1;
    g = 0;
    while (!scl_fall_stb && g < 2000) begin @(negedge clk); g++; end
    nlo = 0;
    while (scl_drive_low && nlo < 2000) begin
      if (nlo > 0 && (scl_fall_stb || scl_rise_stb)) ok = 1'b0;
      nlo++;
      @(negedge clk);
    end
    if (!scl_rise_stb) ok = 1'b0;
    nhi = 0;
    while (!scl_drive_low && nhi < 2000) begin
      if (nhi > 0 && (scl_fall_stb || scl_rise_stb)) ok = 1'b0;
      nhi++;
      @(negedge clk);
    end
    if (!scl_fall_stb) ok = 1'b0;
    chk(nlo == exp_lo, {req, " low length"}, nlo, exp_lo);
    chk(nhi == exp_hi, {req, " high length"}, nhi, exp_hi);
    chk(ok, "R5 strobe placement", ok, 1);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(scl_drive_low == 1'b0, "R1 drive after reset", scl_drive_low, 0);
    chk(scl_fall_stb == 1'b0, "R1 fall strobe after reset", scl_fall_stb, 0);
    chk(scl_rise_stb == 1'b0, "R1 rise strobe after reset", scl_rise_stb, 0);
  endtask

  task automatic t_start();
    start_run(mk(4, 2, 3));
    @(negedge clk);
    chk(scl_drive_low == 1'b1, "R8 drive on start", scl_drive_low, 1);
    chk(scl_fall_stb == 1'b1, "R8 fall strobe on start", scl_fall_stb, 1);
    stop_run();
  endtask

  task automatic t_standard();
    start_run(mk(93, 0, 3));
    measure("R2 R4 standard", 96, 96);
    measure("R4 standard second", 96, 96);
    stop_run();
  endtask

  task automatic t_fast();
    start_run(mk(28, 14, 3));
    measure("R3 fast", 31, 17);
    stop_run();
    start_run(mk(8, 4, 3));
    measure("R3 fast plus", 11, 7);
    stop_run();
  endtask

  task automatic t_mid_ignored();
    start_run(mk(8, 4, 8'hFF));
    measure("R10 middle bits set", 11, 7);
    stop_run();
  endtask

  task automatic t_stretch();
    int n, g;
    start_run(mk(4, 4, 3));
    g = 0;
    while (!scl_rise_stb && g < 2000) begin @(negedge clk); g++; end
    n = 1;
    hold_low = 1'b1;
    g = 0;
    while (g < 2000) begin
      @(negedge clk);
      g++;
      if (scl_drive_low) break;
      n++;
      if (n == 11) hold_low = 1'b0;
    end
    chk(n == 17, "R6 stretched high length", n, 17);
    chk(scl_fall_stb == 1'b1, "R6 fall after stretch", scl_fall_stb, 1);
    stop_run();
  endtask

  task automatic t_word_change();
    int g;
    start_run(mk(10, 5, 3));
    g = 0;
    while (!scl_fall_stb && g < 2000) begin @(negedge clk); g++; end
    ctl_word = mk(20, 0, 3);
    measure("R9 old low new high", 13, 23);
    measure("R9 new word", 23, 23);
    stop_run();
  endtask

  task automatic t_disable();
    int n, g;
    bit quiet;
    start_run(mk(5, 2, 3));
    g = 0;
    while (!scl_fall_stb && g < 2000) begin @(negedge clk); g++; end
    n = 1;
    while (n < 8) begin @(negedge clk); n++; end
    run_en = 1'b0;
    @(negedge clk);
    chk(scl_drive_low == 1'b0, "R7 drive after disable", scl_drive_low, 0);
    chk(scl_rise_stb == 1'b0, "R7 no rise at expiry", scl_rise_stb, 0);
    quiet = 1'b1;
    repeat (20) begin
      @(negedge clk);
      if (scl_drive_low || scl_fall_stb || scl_rise_stb) quiet = 1'b0;
    end
    chk(quiet, "R7 stays parked", quiet, 1);
  endtask

  initial begin
    t_reset();
    t_start();
    t_standard();
    t_fast();
    t_mid_ignored();
    t_stretch();
    t_word_change();
    t_disable();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule